// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns an oscillator-rate enable of nominally 32,768 pulses per second into a one-second tick for a real-time clock. The crystal is not trimmed. Rate error is corrected digitally instead. A signed 5-bit calibration word chooses how many minutes of a repeating 64-minute cycle contain one altered second. In each of those minutes, the opening second is cut short when the sign asks for a faster clock, or stretched when it asks for a slower one. The size of each alteration is tied to the divide-by-256 stage: a shortened second loses one full stage period (256 input pulses), and a lengthened second gains half a stage period (128 input pulses). One calibration step therefore removes 512 pulses or adds 256 pulses per 64-minute cycle.

A stop input freezes the whole divider. A separate divider, which calibration does not affect, makes a 512 Hz square wave (one period every 64 enabled input pulses). This wave is placed on the test output only while frequency-test mode is on, the divider is running, and the seconds register is being read. The wave lets a production tester measure the raw oscillator rate. The block also reports which minute of the 64-minute cycle is in progress.

Counts are parameters. The defaults describe the real oscillator and a 60-second minute. A smaller configuration exercises the same behaviour in fewer cycles.

Top module: `rtcp_prescaler`

## Requirements
- R1: With a calibration magnitude of 0, every second lasts exactly CYC_PER_SEC enabled input pulses, for either sign value.
- R2: With cal_sign = 1 (speed up) and magnitude N, the first second of each of minutes 0 to 2N-1 of the 64-minute cycle lasts CYC_PER_SEC - CAL_STEP enabled pulses. All other seconds are nominal.
- R3: With cal_sign = 0 (slow down) and magnitude N, the first second of each of minutes 0 to 2N-1 lasts CYC_PER_SEC + CAL_STEP/2 enabled pulses. All other seconds are nominal.
- R4: min_idx counts 0 to 63 and then wraps. It steps by one in the same cycle as the tick that opens a new minute. A minute is SEC_PER_MIN seconds.
- R5: The calibration inputs are sampled during reset and at the start of each 64-minute cycle. A change in the middle of a cycle has no effect until the next cycle starts.
- R6: While stop = 1, no pulse advances either divider, no tick is produced, and min_idx holds. Counting resumes from where it stopped.
- R7: A cycle with osc_en = 0 does not advance either divider.
- R8: tick_1hz is high for exactly one clock. That clock directly follows the enabled edge that completes a second.
- R9: test_out carries a square wave that toggles every TEST_HALF enabled pulses and starts low after reset. It is visible only when ft_en = 1, stop = 0 and sec_rd = 1; otherwise test_out is 0.
- R10: The period of the test wave is the same for every calibration setting.
- R11: During and straight after reset, tick_1hz = 0, min_idx = 0 and test_out = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also loads the calibration inputs |
| osc_en | input | 1 | One pulse per oscillator period |
| stop | input | 1 | Freezes both dividers when high |
| cal_sign | input | 1 | 1 = speed the clock up, 0 = slow it down |
| cal_mag | input | 5 | Calibration magnitude, 0 to 31 |
| ft_en | input | 1 | Frequency-test mode enable |
| sec_rd | input | 1 | High while the seconds register is being read |
| tick_1hz | output | 1 | One-clock pulse at the end of each second |
| min_idx | output | 6 | Minute of the current 64-minute cycle |
| test_out | output | 1 | Gated 512 Hz test wave |

## Verification
A second counter left in a wrong state shows up at the very next tick, as an interval that is not one of the three allowed second lengths. A wrong second-in-minute or minute counter may keep every interval legal. It then appears either as a min_idx step at the wrong tick, or as altered seconds in the wrong minutes. The latter becomes visible only over a full 64-minute cycle, so each calibration setting is followed for one whole cycle. A latched calibration word taken at the wrong moment stays hidden until the cycle boundary. A fault in the test-wave divider is visible within one half period of test_out.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

    localparam int MAG_W         = 5;
    localparam int MIN_PER_CYCLE = 64;
    localparam int MIN_W         = $clog2(MIN_PER_CYCLE);

    // Latched calibration word: direction and number of steps.
    typedef struct packed {
        logic             speed_up;
        logic [MAG_W-1:0] steps;
    } cal_t;

    // Length class of the second in progress.
    typedef enum logic [1:0] {
        SEC_NOMINAL = 2'd0,
        SEC_SHORT   = 2'd1,
        SEC_LONG    = 2'd2
    } sec_kind_e;

    // Each step covers two minutes. Only the opening second of a covered
    // minute is altered.
    function automatic sec_kind_e classify_second(
        input cal_t             cal,
        input logic [MIN_W-1:0] minute,
        input logic             opening_sec
    );
        logic [MIN_W-1:0] span;
        span = {cal.steps, 1'b0};
        if (!opening_sec || (minute >= span)) begin
            return SEC_NOMINAL;
        end
        return cal.speed_up ? SEC_SHORT : SEC_LONG;
    endfunction

endpackage

// File: rtl/rtcp_sec_div.sv
module rtcp_sec_div
    import rtcp_pkg::*;
#(
    parameter int CYC_PER_SEC = 32768,
    parameter int CAL_STEP    = 256
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      step_en,
    input  sec_kind_e kind,
    output logic      sec_wrap,
    output logic      tick
);

    localparam int LONG_LEN  = CYC_PER_SEC + CAL_STEP / 2;
    localparam int SHORT_LEN = CYC_PER_SEC - CAL_STEP;
    localparam int CNT_W     = $clog2(LONG_LEN);

    localparam logic [CNT_W-1:0] LAST_NOM   = CNT_W'(CYC_PER_SEC - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        unique case (kind)
            SEC_SHORT: last = LAST_SHORT;
            SEC_LONG:  last = LAST_LONG;
            default:   last = LAST_NOM;
        endcase
    end

    assign sec_wrap = step_en && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= sec_wrap;
            if (sec_wrap) begin
                cnt_q <= '0;
            end else if (step_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtcp_min_seq.sv
module rtcp_min_seq
    import rtcp_pkg::*;
#(
    parameter int SEC_PER_MIN = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  cal_t             cal_in,
    input  logic             sec_wrap,
    output logic [MIN_W-1:0] min_idx,
    output sec_kind_e        kind
);

    localparam int SEC_W = $clog2(SEC_PER_MIN + 1);
    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] LAST_MIN = MIN_W'(MIN_PER_CYCLE - 1);

    logic [SEC_W-1:0] sec_q;
    cal_t             cal_q;
    logic             min_end;
    logic             cyc_end;

    assign min_end = sec_wrap && (sec_q == LAST_SEC);
    assign cyc_end = min_end && (min_idx == LAST_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q   <= '0;
            min_idx <= '0;
            cal_q   <= cal_in;
        end else begin
            if (sec_wrap) begin
                sec_q <= (sec_q == LAST_SEC) ? '0 : sec_q + 1'b1;
            end
            if (min_end) begin
                min_idx <= (min_idx == LAST_MIN) ? '0 : min_idx + 1'b1;
            end
            if (cyc_end) begin
                cal_q <= cal_in;
            end
        end
    end

    assign kind = classify_second(cal_q, min_idx, sec_q == '0);

endmodule

// File: rtl/rtcp_ft_gen.sv
module rtcp_ft_gen #(
    parameter int TEST_HALF = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    output logic wave
);

    localparam int HW = $clog2(TEST_HALF + 1);
    localparam logic [HW-1:0] LAST = HW'(TEST_HALF - 1);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            wave  <= 1'b0;
        end else if (step_en) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                wave  <= ~wave;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtcp_prescaler.sv
module rtcp_prescaler
    import rtcp_pkg::*;
#(
    parameter int CYC_PER_SEC = 32768,
    parameter int CAL_STEP    = 256,
    parameter int SEC_PER_MIN = 60,
    parameter int TEST_HALF   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic             stop,
    input  logic             cal_sign,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             ft_en,
    input  logic             sec_rd,
    output logic             tick_1hz,
    output logic [MIN_W-1:0] min_idx,
    output logic             test_out
);

    logic      step_en;
    logic      sec_wrap;
    logic      ft_wave;
    sec_kind_e kind;
    cal_t      cal_in;

    assign step_en = osc_en && !stop;
    assign cal_in  = '{speed_up: cal_sign, steps: cal_mag};

    rtcp_sec_div #(
        .CYC_PER_SEC(CYC_PER_SEC),
        .CAL_STEP   (CAL_STEP)
    ) u_sec_div (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .kind    (kind),
        .sec_wrap(sec_wrap),
        .tick    (tick_1hz)
    );

    rtcp_min_seq #(
        .SEC_PER_MIN(SEC_PER_MIN)
    ) u_min_seq (
        .clk     (clk),
        .rst     (rst),
        .cal_in  (cal_in),
        .sec_wrap(sec_wrap),
        .min_idx (min_idx),
        .kind    (kind)
    );

    rtcp_ft_gen #(
        .TEST_HALF(TEST_HALF)
    ) u_ft_gen (
        .clk    (clk),
        .rst    (rst),
        .step_en(step_en),
        .wave   (ft_wave)
    );

    assign test_out = ft_wave && ft_en && !stop && sec_rd;

endmodule

// File: rtl/rtcp_prescaler_chk.sv
module rtcp_prescaler_chk #(
    parameter int CYC_PER_SEC = 32768,
    parameter int CAL_STEP    = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       osc_en,
    input logic       stop,
    input logic       ft_en,
    input logic       sec_rd,
    input logic       tick_1hz,
    input logic [5:0] min_idx,
    input logic       test_out
);

    localparam logic [31:0] MIN_LEN = 32'(CYC_PER_SEC - CAL_STEP);
    localparam logic [31:0] MAX_LEN = 32'(CYC_PER_SEC + CAL_STEP / 2);

    logic [31:0] en_cnt;
    logic        step;

    assign step = osc_en && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_cnt <= '0;
        end else if (tick_1hz) begin
            en_cnt <= {31'd0, step};
        end else begin
            en_cnt <= en_cnt + {31'd0, step};
        end
    end

    // R8
    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_1hz |=> !tick_1hz);

    // R6
    stop_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !tick_1hz);

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> $stable(min_idx));

    // R4
    min_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(min_idx) |-> tick_1hz);

    // R4
    min_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && (min_idx != $past(min_idx))) |-> (min_idx == $past(min_idx) + 6'd1));

    // R1 R2 R3
    sec_len_chk: assert property (@(posedge clk) disable iff (rst)
        tick_1hz |-> ((en_cnt >= MIN_LEN) && (en_cnt <= MAX_LEN)));

    // R9
    ft_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ft_en && sec_rd && !stop && $past(ft_en && sec_rd && !stop) && !$past(osc_en))
            |-> $stable(test_out));

endmodule

bind rtcp_prescaler rtcp_prescaler_chk #(
    .CYC_PER_SEC(CYC_PER_SEC),
    .CAL_STEP   (CAL_STEP)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .osc_en  (osc_en),
    .stop    (stop),
    .ft_en   (ft_en),
    .sec_rd  (sec_rd),
    .tick_1hz(tick_1hz),
    .min_idx (min_idx),
    .test_out(test_out)
);

// File: tb/tb_rtcp_prescaler.sv
`timescale 1ns/1ps
module tb_rtcp_prescaler;

    localparam int CPS  = 64;
    localparam int STEP = 8;
    localparam int SPM  = 3;
    localparam int HALF = 4;
    localparam int SPC  = SPM * 64;

    // {sign, magnitude, expected enabled pulses in one 64-minute cycle}
    localparam logic [37:0] VEC [0:5] = '{
        {1'b0, 5'd0,  32'd12288},
        {1'b1, 5'd0,  32'd12288},
        {1'b1, 5'd1,  32'd12272},
        {1'b0, 5'd2,  32'd12304},
        {1'b1, 5'd31, 32'd11792},
        {1'b0, 5'd31, 32'd12536}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b1;
    logic       stop = 1'b0;
    logic       cal_sign = 1'b0;
    logic [4:0] cal_mag = 5'd0;
    logic       ft_en = 1'b0;
    logic       sec_rd = 1'b0;
    logic       tick_1hz;
    logic [5:0] min_idx;
    logic       test_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rtcp_prescaler #(
        .CYC_PER_SEC(CPS),
        .CAL_STEP   (STEP),
        .SEC_PER_MIN(SPM),
        .TEST_HALF  (HALF)
    ) dut (
        .clk     (clk),
        .rst     (rst),
        .osc_en  (osc_en),
        .stop    (stop),
        .cal_sign(cal_sign),
        .cal_mag (cal_mag),
        .ft_en   (ft_en),
        .sec_rd  (sec_rd),
        .tick_1hz(tick_1hz),
        .min_idx (min_idx),
        .test_out(test_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic sg, input int mg, input int s);
        int m;
        bit opening;
        m = (s % SPC) / SPM;
        opening = ((s % SPM) == 0);
        if (opening && (m < 2 * mg)) return sg ? CPS - STEP : CPS + STEP / 2;
        return CPS;
    endfunction

    task automatic do_reset(input logic sg, input logic [4:0] mg);
        @(negedge clk);
        rst = 1'b1; cal_sign = sg; cal_mag = mg;
        stop = 1'b0; osc_en = 1'b1; ft_en = 1'b0; sec_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(posedge clk);
            if (osc_en && !stop) n++;
            @(negedge clk);
        end while (!tick_1hz);
    endtask

    task automatic check_seconds(input int first_s, input int nsec, input logic sg,
                                 input int mg, input string tag, inout longint total);
        int n;
        for (int k = 0; k < nsec; k++) begin
            int s;
            s = first_s + k;
            wait_tick(n);
            check(n == exp_len(sg, mg, s), tag, "second length", n, exp_len(sg, mg, s));
            check(int'(min_idx) == ((s + 1) / SPM) % 64, "R4", "minute index",
                  min_idx, ((s + 1) / SPM) % 64);
            total += n;
        end
    endtask

    task automatic count_toggles(output int toggles, output int first_hi);
        logic prev;
        prev = test_out;
        toggles = 0;
        first_hi = -1;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (test_out != prev) toggles++;
            if (test_out && first_hi < 0) first_hi = i;
            prev = test_out;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        longint total;
        int n, errs, ticks, tg, fh;
        logic [5:0] held;

        // R11: reset state, with test mode requested
        ft_en = 1'b1; sec_rd = 1'b1;
        repeat (3) @(negedge clk);
        check(tick_1hz == 1'b0, "R11", "tick in reset", tick_1hz, 0);
        check(min_idx == 6'd0, "R11", "minute in reset", min_idx, 0);
        check(test_out == 1'b0, "R11", "test out in reset", test_out, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(tick_1hz == 1'b0 && min_idx == 6'd0, "R11", "state after reset",
              {tick_1hz, min_idx}, 0);

        // Vector table: one full 64-minute cycle per calibration setting
        for (int v = 0; v < 6; v++) begin
            logic sg;
            logic [4:0] mg;
            string tag;
            sg = VEC[v][37];
            mg = VEC[v][36:32];
            tag = (mg == 5'd0) ? "R1" : (sg ? "R2" : "R3");
            do_reset(sg, mg);
            total = 0;
            check_seconds(0, SPC, sg, int'(mg), tag, total);
            check(total == longint'(VEC[v][31:0]), tag, "cycle length", total, VEC[v][31:0]);
        end

        // R8: tick lasts one clock
        do_reset(1'b0, 5'd0);
        wait_tick(n);
        check(n == CPS, "R1", "first second", n, CPS);
        @(posedge clk); @(negedge clk);
        check(tick_1hz == 1'b0, "R8", "tick width", tick_1hz, 0);

        // R5: mid-cycle calibration change waits for the next cycle
        do_reset(1'b0, 5'd0);
        total = 0;
        check_seconds(0, 5, 1'b0, 0, "R5", total);
        cal_sign = 1'b1; cal_mag = 5'd3;
        check_seconds(5, SPC - 5, 1'b0, 0, "R5", total);
        check(total == SPC * CPS, "R5", "old cycle length", total, SPC * CPS);
        total = 0;
        check_seconds(SPC, SPC, 1'b1, 3, "R5", total);
        check(total == SPC * CPS - 6 * STEP, "R5", "new cycle length", total, SPC * CPS - 6 * STEP);

        // R6 R7: stop window and gaps in osc_en
        do_reset(1'b0, 5'd0);
        n = 0; errs = 0; ticks = 0;
        held = min_idx;
        for (int i = 0; i < 200; i++) begin
            bit inc, exp_t;
            stop = (i >= 20 && i < 70);
            osc_en = !(i >= 100 && (i % 2) == 1);
            @(posedge clk);
            inc = osc_en && !stop;
            if (inc) n++;
            @(negedge clk);
            exp_t = inc && (n == CPS);
            if (exp_t) n = 0;
            if (tick_1hz != exp_t) errs++;
            if (stop && min_idx != held) errs++;
            if (tick_1hz) ticks++;
        end
        check(errs == 0, "R6", "tick timing around stop", errs, 0);
        check(ticks == 1, "R7", "ticks over 100 enabled pulses", ticks, 1);
        stop = 1'b0; osc_en = 1'b1;

        // R9: test wave shape and gating
        do_reset(1'b0, 5'd0);
        ft_en = 1'b1; sec_rd = 1'b1;
        count_toggles(tg, fh);
        check(tg == 64 / HALF, "R9", "test toggles", tg, 64 / HALF);
        check(fh == HALF - 1, "R9", "first high", fh, HALF - 1);
        errs = 0;
        sec_rd = 1'b0;
        for (int i = 0; i < 12; i++) begin @(posedge clk); @(negedge clk); if (test_out) errs++; end
        sec_rd = 1'b1; ft_en = 1'b0;
        for (int i = 0; i < 12; i++) begin @(posedge clk); @(negedge clk); if (test_out) errs++; end
        ft_en = 1'b1; stop = 1'b1;
        for (int i = 0; i < 12; i++) begin @(posedge clk); @(negedge clk); if (test_out) errs++; end
        check(errs == 0, "R9", "gated test out", errs, 0);
        stop = 1'b0;

        // R10: calibration does not change the test wave
        do_reset(1'b1, 5'd31);
        ft_en = 1'b1; sec_rd = 1'b1;
        count_toggles(tg, fh);
        check(tg == 64 / HALF, "R10", "toggles with fast cal", tg, 64 / HALF);
        do_reset(1'b0, 5'd31);
        ft_en = 1'b1; sec_rd = 1'b1;
        count_toggles(tg, fh);
        check(tg == 64 / HALF, "R10", "toggles with slow cal", tg, 64 / HALF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule